// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit two's-complement operands and a single carry-in, and produces the 16-bit sum, the unsigned carry-out and a signed overflow flag. It has no clock and no registers. It is meant to sit inside a wider datapath wherever a full-width add must settle in a short, predictable number of gate levels.

The operand is cut into four slices of four bits. Each slice works out a generate bit and a propagate bit for every position, and from them a carry for each position. Every one of those carries is a flat sum of products over the slice's generate and propagate bits and the slice's own carry-in, so no carry ripples from one bit to the next. Each slice also reports one generate and one propagate bit for the slice as a whole. A second-level lookahead unit uses these four pairs and the adder's carry-in to compute the carry into every slice, so no carry ripples between slices either.

Signed overflow is the exclusive-OR of the carry into bit 15 and the carry out of bit 15.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals (`opA` + `opB` + `carryIn`) modulo 2^16 for every combination of inputs.
- R2: `carryOut` equals bit 16 of the 17-bit unsigned result of `opA` + `opB` + `carryIn`.
- R3: `overflow` is 1 exactly when `opA[15]` equals `opB[15]` and `sum[15]` differs from them, that is, when the carry into bit 15 differs from the carry out of bit 15.
- R4: When every bit position propagates (`opA` XOR `opB` is 0xFFFF), the adder's carry-in passes through all four slices. With a carry-in of 1 the result is `sum` = 0x0000 and `carryOut` = 1. With a carry-in of 0 the result is `sum` = 0xFFFF and `carryOut` = 0.
- R5: A slice that generates a carry by itself delivers that carry to the next slice whatever its own carry-in is. For example, 0x000F + 0x0001 gives 0x0010 when `carryIn` is 0 and 0x0011 when `carryIn` is 1.
- R6: With the corner operands the outputs are as follows:
  - 0x7FFF + 0x0001 gives `sum` 0x8000, `carryOut` 0 and `overflow` 1.
  - 0x8000 + 0x8000 gives `sum` 0x0000, `carryOut` 1 and `overflow` 1.
  - 0xFFFF + 0x0001 with `carryIn` 1 gives `sum` 0x0001, `carryOut` 1 and `overflow` 0.
- R7: With all inputs at zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand, two's complement |
| opB | input | 16 | Second operand, two's complement |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum modulo 2^16 |
| carryOut | output | 1 | Carry out of bit 15 |
| overflow | output | 1 | Signed overflow of the addition |

## Verification
The bench first sweeps 65,536 structured operand pairs, with the carry-in alternating between them. It then runs random operands. Along the way it targets the long propagate chain (0xFFFF + 0 with a carry-in), where a lookahead unit that dropped the carry-in term from a slice carry would leave a wrong upper slice. It also targets the slice-generate case, which catches a slice generate that was mis-weighted or left out. Finally it targets the signed boundaries 0x7FFF+1 and 0x8000+0x8000: an overflow flag taken from the wrong carry pair, or from carry-out alone, would report the wrong flag there.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GROUP_W    = 4;
  localparam int NUM_GROUPS = 4;
  localparam int ADD_W      = GROUP_W * NUM_GROUPS;

  // One slice's generate/propagate summary
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;

  // Strobes from the lookahead control to the slice datapaths
  typedef struct packed {
    logic [NUM_GROUPS-1:0] groupCin;
    logic                  carryOut;
  } carryStrobe_t;

  // Carry into position pos, built as a flat sum of products:
  // OR over j<pos of g[j]&p[j+1..pos-1], plus cin&p[0..pos-1].
  function automatic logic flatCarry(input logic [ADD_W-1:0] g,
                                     input logic [ADD_W-1:0] p,
                                     input logic cin,
                                     input int pos);
    logic acc;
    logic term;
    acc = cin;
    for (int k = 0; k < ADD_W; k++)
      if (k < pos) acc = acc & p[k];
    for (int j = 0; j < ADD_W; j++) begin
      if (j < pos) begin
        term = g[j];
        for (int k = 0; k < ADD_W; k++)
          if (k > j && k < pos) term = term & p[k];
        acc = acc | term;
      end
    end
    return acc;
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
(
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cin,
  output logic [GROUP_W-1:0] sum,
  output gpPair_t            grpGp,
  output logic               msbCin,
  output logic               cOutLocal
);
  localparam int PAD = ADD_W - GROUP_W;

  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W:0]   carries;
  logic [ADD_W-1:0]   genExt;
  logic [ADD_W-1:0]   propExt;

  assign bitGen  = a & b;
  assign bitProp = a ^ b;
  assign genExt  = {{PAD{1'b0}}, bitGen};
  assign propExt = {{PAD{1'b0}}, bitProp};

  always_comb begin
    for (int i = 0; i <= GROUP_W; i++)
      carries[i] = flatCarry(genExt, propExt, cin, i);
  end

  assign sum        = bitProp ^ carries[GROUP_W-1:0];
  assign grpGp.gen  = flatCarry(genExt, propExt, 1'b0, GROUP_W);
  assign grpGp.prop = &bitProp;
  assign msbCin     = carries[GROUP_W-1];
  assign cOutLocal  = carries[GROUP_W];

  always_comb begin
    // R5
    grp_gen_chk: assert (!grpGp.gen || cOutLocal)
      else $error("slice generate did not yield carry-out");
    // R4
    grp_prop_chk: assert (!grpGp.prop || (cOutLocal == cin))
      else $error("slice propagate did not pass carry-in");
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
(
  input  logic [NUM_GROUPS-1:0] grpGen,
  input  logic [NUM_GROUPS-1:0] grpProp,
  input  logic                  cin,
  output carryStrobe_t          strobe
);
  localparam int PAD = ADD_W - NUM_GROUPS;

  logic [ADD_W-1:0] genExt;
  logic [ADD_W-1:0] propExt;

  assign genExt  = {{PAD{1'b0}}, grpGen};
  assign propExt = {{PAD{1'b0}}, grpProp};

  always_comb begin
    for (int k = 0; k < NUM_GROUPS; k++)
      strobe.groupCin[k] = flatCarry(genExt, propExt, cin, k);
    strobe.carryOut = flatCarry(genExt, propExt, cin, NUM_GROUPS);
  end

  always_comb begin
    // R2
    lookahead_chain_chk: assert (strobe.carryOut ==
        (grpGen[NUM_GROUPS-1] | (grpProp[NUM_GROUPS-1] & strobe.groupCin[NUM_GROUPS-1])))
      else $error("top slice carry disagrees with chained form");
    // R4
    lookahead_base_chk: assert (strobe.groupCin[0] == cin)
      else $error("lowest slice carry-in is not the adder carry-in");
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        carryIn,
  output logic [15:0] sum,
  output logic        carryOut,
  output logic        overflow
);
  logic [NUM_GROUPS-1:0] grpGen;
  logic [NUM_GROUPS-1:0] grpProp;
  logic [NUM_GROUPS-1:0] grpMsbCin;
  logic [NUM_GROUPS-1:0] grpCout;
  carryStrobe_t          strobe;

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_slice
    gpPair_t sliceGp;
    cla_group u_group (
      .a        (opA[gi*GROUP_W +: GROUP_W]),
      .b        (opB[gi*GROUP_W +: GROUP_W]),
      .cin      (strobe.groupCin[gi]),
      .sum      (sum[gi*GROUP_W +: GROUP_W]),
      .grpGp    (sliceGp),
      .msbCin   (grpMsbCin[gi]),
      .cOutLocal(grpCout[gi])
    );
    assign grpGen[gi]  = sliceGp.gen;
    assign grpProp[gi] = sliceGp.prop;
  end

  cla_lookahead u_lookahead (
    .grpGen (grpGen),
    .grpProp(grpProp),
    .cin    (carryIn),
    .strobe (strobe)
  );

  assign carryOut = strobe.carryOut;
  assign overflow = grpMsbCin[NUM_GROUPS-1] ^ strobe.carryOut;

  always_comb begin
    // R3
    no_overflow_chk: assert (!overflow ||
        ((opA[ADD_W-1] == opB[ADD_W-1]) && (sum[ADD_W-1] != opA[ADD_W-1])))
      else $error("overflow raised without a sign violation");
    // R2
    carry_agree_chk: assert (carryOut == grpCout[NUM_GROUPS-1])
      else $error("lookahead carry-out disagrees with top slice");
  end
endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;
  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sum;
  logic        carryOut;
  logic        overflow;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cla_adder16 u_dut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input string req);
    logic [16:0] full;
    logic        expOvf;
    opA = a; opB = b; carryIn = c;
    #5;
    full   = {1'b0, a} + {1'b0, b} + {16'd0, c};
    expOvf = (a[15] == b[15]) && (full[15] != a[15]);
    checks++;
    if (sum !== full[15:0] || carryOut !== full[16] || overflow !== expOvf) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual sum=%h cout=%b ovf=%b expected sum=%h cout=%b ovf=%b",
               req, a, b, c, sum, carryOut, overflow, full[15:0], full[16], expOvf);
    end
    #5;
  endtask

  task automatic expectExact(input logic [15:0] a, input logic [15:0] b, input logic c,
                             input logic [15:0] es, input logic ec, input logic eo,
                             input string req);
    opA = a; opB = b; carryIn = c;
    #5;
    checks++;
    if (sum !== es || carryOut !== ec || overflow !== eo) begin
      errors++;
      $display("FAIL %s: actual sum=%h cout=%b ovf=%b expected sum=%h cout=%b ovf=%b",
               req, sum, carryOut, overflow, es, ec, eo);
    end
    #5;
  endtask

  initial begin
    #15;
    // R7: all-zero inputs give all-zero outputs
    expectExact(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, "R7");
    // R4: full propagate chain
    expectExact(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, "R4");
    expectExact(16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 1'b0, "R4");
    expectExact(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, 1'b0, "R4");
    // R5: slice generate independent of carry-in
    expectExact(16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0, "R5");
    expectExact(16'h000F, 16'h0001, 1'b1, 16'h0011, 1'b0, 1'b0, "R5");
    expectExact(16'h0F00, 16'h0100, 1'b0, 16'h1000, 1'b0, 1'b0, "R5");
    // R6: signed and unsigned boundaries
    expectExact(16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1, "R6");
    expectExact(16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, "R6");
    expectExact(16'hFFFF, 16'h0001, 1'b1, 16'h0001, 1'b1, 1'b0, "R6");
    // R3: negative overflow with carry-in and no-overflow mixed signs
    expectExact(16'h8000, 16'hFFFF, 1'b0, 16'h7FFF, 1'b1, 1'b1, "R3");
    expectExact(16'h7FFF, 16'h8000, 1'b1, 16'h0000, 1'b1, 1'b0, "R3");
    // R1 R2 R3: structured sweep of every byte pair
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        logic [7:0] x;
        logic [7:0] y;
        x = ai[7:0];
        y = bi[7:0];
        apply({x, ~x}, {y, y}, x[0] ^ y[0], "R1 R2 R3 sweep");
      end
    end
    // R1 R2 R3: random operands
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      apply(ra, rb, 1'($urandom), "R1 R2 R3 random");
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule